// File: doc/BRIEF.md
# Memory-Fetching Configurable CRC Engine

This block computes a cyclic redundancy check over a region of memory. Software sets it up through a small register window on an AHB-Lite slave port. The setup gives the source address, the byte count, the CRC variant and the job mode. A start bit launches the job. The engine then fetches the data itself, one 32-bit word at a time, over a plain request/grant read port that allows a single request in flight. Each returned word is folded into the running CRC in one clock cycle by a combinational network that handles up to four bytes.

When the last byte has been folded, the finished code goes into a result register. In check mode the engine also compares the code with a value that software wrote beforehand and records the outcome as a match flag. In both modes the end of a job sets a done flag in the status register. The done flag drives an interrupt line, which software can gate. Writing one to the done bit acknowledges the job and clears both the flag and the interrupt.

Top module: `crc_fetch_engine`

## Requirements
- R1: Register offsets are control 0x00, source 0x04, length 0x08, expected 0x0C, result 0x10 and status 0x14. Control holds mode in bit 1 (1 = check), variant in bits 3:2 and interrupt enable in bit 4. Bit 0 of control is the start bit and always reads back 0. Source, length (16 bits wide) and expected read back exactly what was written.
- R2: Status bit 0 is busy. Busy is 0 after reset, reads 1 while a started job runs, and returns to 0 once the job completes.
- R3: Variant 0 is an 8-bit CRC: polynomial 0x07, initial value 0, no reflection, no final XOR. Variant 1 is a 16-bit CRC: polynomial 0x1021, initial value 0xFFFF, no reflection, no final XOR. Variants 2 and 3 are the reflected 32-bit CRC: polynomial 0x04C11DB7, initial value and final XOR both 0xFFFFFFFF. Narrow results are zero-extended in the result register.
- R4: Memory words are little-endian. Bits 7:0 of a fetched word are the first byte of the stream.
- R5: On the final word, only the remaining 1 to 3 valid bytes are folded in. The other bytes of that word have no effect on the result.
- R6: A length of zero finishes without any memory request. The result is the variant's initial value after the final XOR: 0x00, 0xFFFF or 0x00000000.
- R7: Status bit 2 is match. In check mode it is set when the result equals the expected register. In operation mode it reads 0. A new start clears it.
- R8: Status bit 1 is done. It sets when a job ends. The irq output equals done ANDed with the interrupt enable. Writing 1 to status bit 1 clears done and therefore irq.
- R9: While busy, writes to control, source, length and expected are ignored, and a start request is dropped.
- R10: Words are fetched from the source address with bits 1:0 cleared, at ascending addresses 4 apart. A job issues exactly ceil(length/4) requests. mem_req stays high with a stable address until granted, and no new request is made until the previous data has returned.
- R11: The slave port is zero-wait: hreadyout is always 1 and hresp is always 0 (OKAY).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsel | input | 1 | Slave select |
| haddr | input | 5 | Byte address inside the register window |
| htrans | input | 2 | Transfer type (bit 1 set = active transfer) |
| hwrite | input | 1 | 1 = write transfer |
| hready | input | 1 | Bus ready; qualifies the address phase |
| hwdata | input | 32 | Write data (data phase) |
| hrdata | output | 32 | Read data (data phase) |
| hreadyout | output | 1 | Slave ready, held at 1 |
| hresp | output | 1 | Slave response, held at OKAY |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Word-aligned byte address of the request |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| irq | output | 1 | Job-complete interrupt |

## Verification
The bench targets byte counts that leave a final word with one, two or three valid bytes, and it places non-zero filler in the unused lanes. A design that folded whole words would return a wrong code, and so would one that read the lanes in big-endian order. Zero-length jobs must finish with the per-variant empty value and no memory request; a design that always fetched once would be visible in the request log. Register writes and a second start during a slowed job must leave the length register and the result untouched, and the request count must match a single job. The bench also checks done acknowledgement, gating of the interrupt enable, and the match flag for equal and unequal expected values.

// File: rtl/crc_pkg.sv
package crc_pkg;

  typedef enum logic [1:0] {
    CRC_V8   = 2'd0,
    CRC_V16  = 2'd1,
    CRC_V32  = 2'd2,
    CRC_VRSV = 2'd3
  } crc_variant_e;

  typedef enum logic [1:0] {
    F_IDLE = 2'd0,
    F_REQ  = 2'd1,
    F_WAIT = 2'd2,
    F_FIN  = 2'd3
  } fetch_state_e;

  // Internal state layout: narrow variants sit in the top bits of 32,
  // the reflected variant uses the whole word shifted right.
  function automatic logic crc_is_reflected(crc_variant_e v);
    return (v == CRC_V32) || (v == CRC_VRSV);
  endfunction

  function automatic logic [31:0] crc_poly(crc_variant_e v);
    case (v)
      CRC_V8:  return 32'h0700_0000;
      CRC_V16: return 32'h1021_0000;
      default: return 32'hEDB8_8320;
    endcase
  endfunction

  function automatic logic [31:0] crc_init(crc_variant_e v);
    case (v)
      CRC_V8:  return 32'h0000_0000;
      CRC_V16: return 32'hFFFF_0000;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] crc_fold_byte(logic [31:0] s, logic [7:0] d,
                                                crc_variant_e v);
    logic [31:0] r;
    logic        fb;
    r = s;
    for (int i = 0; i < 8; i++) begin
      if (crc_is_reflected(v)) begin
        fb = r[0] ^ d[i];
        r  = r >> 1;
      end else begin
        fb = r[31] ^ d[7-i];
        r  = r << 1;
      end
      if (fb) r = r ^ crc_poly(v);
    end
    return r;
  endfunction

  function automatic logic [31:0] crc_finalize(logic [31:0] s, crc_variant_e v);
    case (v)
      CRC_V8:  return {24'h0, s[31:24]};
      CRC_V16: return {16'h0, s[31:16]};
      default: return ~s;
    endcase
  endfunction

endpackage

// File: rtl/crc_fold_unit.sv
module crc_fold_unit
  import crc_pkg::*;
#(
  parameter int BYTES = 4,
  localparam int NB_W = $clog2(BYTES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init_en,
  input  crc_variant_e       variant,
  input  logic               fold_en,
  input  logic [8*BYTES-1:0] word,
  input  logic [NB_W-1:0]    nbytes,
  output logic [31:0]        crc_final
);

  logic [31:0] state_q;
  logic [31:0] chain [BYTES+1];

  assign chain[0] = state_q;

  for (genvar k = 0; k < BYTES; k++) begin : g_lane
    assign chain[k+1] = (NB_W'(k) < nbytes)
                        ? crc_fold_byte(chain[k], word[8*k +: 8], variant)
                        : chain[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= '0;
    else if (init_en) state_q <= crc_init(variant);
    else if (fold_en) state_q <= chain[BYTES];
  end

  assign crc_final = crc_finalize(state_q, variant);

endmodule

// File: rtl/crc_fetch_ctrl.sv
module crc_fetch_ctrl
  import crc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int BYTES  = 4,
  localparam int NB_W  = $clog2(BYTES + 1),
  localparam int OFF_W = $clog2(BYTES),
  localparam int PTR_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PTR_W-1:0]  src_word,
  input  logic [LEN_W-1:0]  len,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  output logic              init_en,
  output logic              fold_en,
  output logic [NB_W-1:0]   fold_nbytes,
  output logic              busy,
  output logic              job_done,
  output logic              fetch_wait
);

  fetch_state_e         st;
  logic [PTR_W-1:0]     ptr;
  logic [LEN_W-1:0]     remain;
  logic                 last_word;

  assign last_word   = (remain <= LEN_W'(BYTES));
  assign fold_nbytes = last_word ? remain[NB_W-1:0] : NB_W'(BYTES);
  assign mem_req     = (st == F_REQ);
  assign mem_addr    = {ptr, {OFF_W{1'b0}}};
  assign fetch_wait  = (st == F_WAIT);
  assign fold_en     = fetch_wait && mem_rvalid;
  assign init_en     = start && (st == F_IDLE);
  assign busy        = (st != F_IDLE);
  assign job_done    = (st == F_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= F_IDLE;
      ptr    <= '0;
      remain <= '0;
    end else begin
      case (st)
        F_IDLE: if (start) begin
          ptr    <= src_word;
          remain <= len;
          st     <= (len == '0) ? F_FIN : F_REQ;
        end
        F_REQ: if (mem_gnt) st <= F_WAIT;
        F_WAIT: if (mem_rvalid) begin
          ptr    <= ptr + PTR_W'(1);
          remain <= remain - LEN_W'(fold_nbytes);
          st     <= last_word ? F_FIN : F_REQ;
        end
        default: st <= F_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/crc_ahb_regs.sv
module crc_ahb_regs
  import crc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int REG_AW = 5,
  localparam int IDX_W = REG_AW - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsel,
  input  logic [REG_AW-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic              hready,
  input  logic [31:0]       hwdata,
  output logic [31:0]       hrdata,
  input  logic              eng_busy,
  input  logic              job_done,
  input  logic [31:0]       job_result,
  output logic              start_pulse,
  output logic              cfg_mode,
  output crc_variant_e      cfg_variant,
  output logic              cfg_irq_en,
  output logic [ADDR_W-1:0] cfg_src,
  output logic [LEN_W-1:0]  cfg_len,
  output logic              busy_view,
  output logic              irq
);

  localparam logic [IDX_W-1:0] IDX_CTRL = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_SRC  = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_LEN  = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_EXP  = IDX_W'(3);
  localparam logic [IDX_W-1:0] IDX_RES  = IDX_W'(4);
  localparam logic [IDX_W-1:0] IDX_STAT = IDX_W'(5);

  logic             dp_valid, dp_write, dp_ok;
  logic [IDX_W-1:0] dp_idx;
  logic             aphase, wr_ok, rd_ok, locked, cfg_wr, start_req;
  logic             start_q, done_q, match_q;
  logic [31:0]      expect_q, result_q;

  assign aphase = hsel && hready && htrans[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_valid <= 1'b0;
      dp_write <= 1'b0;
      dp_ok    <= 1'b0;
      dp_idx   <= '0;
    end else begin
      dp_valid <= aphase;
      if (aphase) begin
        dp_write <= hwrite;
        dp_ok    <= (haddr[1:0] == 2'b00);
        dp_idx   <= haddr[REG_AW-1:2];
      end
    end
  end

  assign wr_ok     = dp_valid && dp_write && dp_ok;
  assign rd_ok     = dp_valid && !dp_write && dp_ok;
  assign locked    = eng_busy || start_q;
  assign cfg_wr    = wr_ok && !locked;
  assign start_req = cfg_wr && (dp_idx == IDX_CTRL) && hwdata[0];
  assign busy_view = locked;
  assign start_pulse = start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_mode    <= 1'b0;
      cfg_variant <= CRC_V8;
      cfg_irq_en  <= 1'b0;
      cfg_src     <= '0;
      cfg_len     <= '0;
      expect_q    <= '0;
      start_q     <= 1'b0;
    end else begin
      start_q <= start_req;
      if (cfg_wr) begin
        case (dp_idx)
          IDX_CTRL: begin
            cfg_mode    <= hwdata[1];
            cfg_variant <= crc_variant_e'(hwdata[3:2]);
            cfg_irq_en  <= hwdata[4];
          end
          IDX_SRC: cfg_src  <= hwdata[ADDR_W-1:0];
          IDX_LEN: cfg_len  <= hwdata[LEN_W-1:0];
          IDX_EXP: expect_q <= hwdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      match_q  <= 1'b0;
      result_q <= '0;
    end else if (job_done) begin
      done_q   <= 1'b1;
      match_q  <= cfg_mode && (job_result == expect_q);
      result_q <= job_result;
    end else if (start_q) begin
      done_q  <= 1'b0;
      match_q <= 1'b0;
    end else if (wr_ok && (dp_idx == IDX_STAT) && hwdata[1]) begin
      done_q <= 1'b0;
    end
  end

  assign irq = done_q && cfg_irq_en;

  always_comb begin
    hrdata = '0;
    if (rd_ok) begin
      case (dp_idx)
        IDX_CTRL: hrdata = {27'h0, cfg_irq_en, cfg_variant, cfg_mode, 1'b0};
        IDX_SRC:  hrdata = 32'(cfg_src);
        IDX_LEN:  hrdata = 32'(cfg_len);
        IDX_EXP:  hrdata = expect_q;
        IDX_RES:  hrdata = result_q;
        IDX_STAT: hrdata = {29'h0, match_q, done_q, busy_view};
        default:  hrdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/crc_fetch_engine.sv
module crc_fetch_engine
  import crc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int REG_AW = 5,
  parameter int MEM_W  = 32,
  localparam int BYTES = MEM_W / 8,
  localparam int NB_W  = $clog2(BYTES + 1),
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsel,
  input  logic [REG_AW-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic              hready,
  input  logic [31:0]       hwdata,
  output logic [31:0]       hrdata,
  output logic              hreadyout,
  output logic              hresp,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [MEM_W-1:0]  mem_rdata,
  output logic              irq
);

  // Named internal events, also observed by the bound checker.
  logic              start_accept;
  logic              fetch_wait;
  logic              fold_fire;
  logic              job_done;
  logic              eng_busy;
  logic              busy_view;
  logic              init_en;
  logic [NB_W-1:0]   fold_nbytes;
  logic              cfg_mode;
  logic              cfg_irq_en;
  crc_variant_e      cfg_variant;
  logic [ADDR_W-1:0] cfg_src;
  logic [LEN_W-1:0]  cfg_len;
  logic [31:0]       crc_final;

  assign hreadyout = 1'b1;
  assign hresp     = 1'b0;

  crc_ahb_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .REG_AW(REG_AW)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .hsel        (hsel),
    .haddr       (haddr),
    .htrans      (htrans),
    .hwrite      (hwrite),
    .hready      (hready),
    .hwdata      (hwdata),
    .hrdata      (hrdata),
    .eng_busy    (eng_busy),
    .job_done    (job_done),
    .job_result  (crc_final),
    .start_pulse (start_accept),
    .cfg_mode    (cfg_mode),
    .cfg_variant (cfg_variant),
    .cfg_irq_en  (cfg_irq_en),
    .cfg_src     (cfg_src),
    .cfg_len     (cfg_len),
    .busy_view   (busy_view),
    .irq         (irq)
  );

  crc_fetch_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BYTES(BYTES)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start_accept),
    .src_word    (cfg_src[ADDR_W-1:OFF_W]),
    .len         (cfg_len),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_gnt     (mem_gnt),
    .mem_rvalid  (mem_rvalid),
    .init_en     (init_en),
    .fold_en     (fold_fire),
    .fold_nbytes (fold_nbytes),
    .busy        (eng_busy),
    .job_done    (job_done),
    .fetch_wait  (fetch_wait)
  );

  crc_fold_unit #(.BYTES(BYTES)) u_fold (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_en   (init_en),
    .variant   (cfg_variant),
    .fold_en   (fold_fire),
    .word      (mem_rdata),
    .nbytes    (fold_nbytes),
    .crc_final (crc_final)
  );

endmodule

// File: rtl/crc_fetch_engine_chk.sv
module crc_fetch_engine_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_gnt,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              fetch_wait,
  input logic              fold_fire,
  input logic              job_done,
  input logic              start_accept,
  input logic              eng_busy,
  input logic              busy_view,
  input logic              cfg_irq_en,
  input logic [LEN_W-1:0]  cfg_len,
  input logic              irq
);

  AST_NO_REQ_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_wait |-> !mem_req);  // R10

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));  // R10

  AST_FOLD_IN_JOB: assert property (@(posedge clk) disable iff (!rst_n)
    fold_fire |-> busy_view);  // R10

  AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_accept |=> eng_busy);  // R2

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    job_done |=> !eng_busy);  // R2

  AST_LEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_view && $past(busy_view)) |-> $stable(cfg_len));  // R9

  AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (job_done && cfg_irq_en) |=> irq);  // R8

endmodule

bind crc_fetch_engine crc_fetch_engine_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mem_req      (mem_req),
  .mem_gnt      (mem_gnt),
  .mem_addr     (mem_addr),
  .fetch_wait   (fetch_wait),
  .fold_fire    (fold_fire),
  .job_done     (job_done),
  .start_accept (start_accept),
  .eng_busy     (eng_busy),
  .busy_view    (busy_view),
  .cfg_irq_en   (cfg_irq_en),
  .cfg_len      (cfg_len),
  .irq          (irq)
);

// File: tb/crc_fetch_engine_bench.sv
module crc_fetch_engine_bench;

  localparam logic [4:0] A_CTRL = 5'h00, A_SRC = 5'h04, A_LEN = 5'h08,
                         A_EXP  = 5'h0C, A_RES = 5'h10, A_STAT = 5'h14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hsel = 1'b0, hwrite = 1'b0, hready = 1'b1;
  logic [4:0]  haddr = '0;
  logic [1:0]  htrans = 2'b00;
  logic [31:0] hwdata = '0;
  logic [31:0] hrdata;
  logic        hreadyout, hresp;
  logic        mem_req, mem_gnt, mem_rvalid;
  logic [31:0] mem_addr, mem_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  logic [31:0] mem_words [64];
  int          gnt_lat = 0, rv_lat = 0;
  int          n_grants = 0, viol = 0;
  logic [31:0] grant_log [256];

  always #4 clk = ~clk;

  crc_fetch_engine u_crc_fetch_engine (
    .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hready(hready), .hwdata(hwdata), .hrdata(hrdata),
    .hreadyout(hreadyout), .hresp(hresp), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .irq(irq)
  );

  // Memory responder: one request at a time, adjustable latencies.
  initial begin : mem_model
    logic        pend;
    int          gcnt, rcnt;
    logic [31:0] paddr;
    pend = 1'b0; gcnt = 0; rcnt = 0; paddr = '0;
    mem_gnt = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_rvalid) mem_rvalid = 1'b0;
      if (mem_gnt) begin
        mem_gnt = 1'b0;
        pend    = 1'b1;
        rcnt    = rv_lat;
      end else if (pend) begin
        if (mem_req) viol++;
        if (rcnt == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata  = mem_words[paddr[7:2]];
          pend       = 1'b0;
        end else rcnt--;
      end else if (mem_req) begin
        if (gcnt >= gnt_lat) begin
          mem_gnt = 1'b1;
          paddr   = mem_addr;
          grant_log[n_grants[7:0]] = mem_addr;
          n_grants++;
          gcnt = 0;
        end else gcnt++;
      end
    end
  end

  task automatic report_and_end();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    report_and_end();
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ahb_write(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    hsel = 1'b1; htrans = 2'b10; hwrite = 1'b1; haddr = a;
    @(negedge clk);
    hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0; hwdata = d;
    @(negedge clk);
  endtask

  task automatic ahb_read(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    hsel = 1'b1; htrans = 2'b10; hwrite = 1'b0; haddr = a;
    @(negedge clk);
    hsel = 1'b0; htrans = 2'b00;
    d = hrdata;
  endtask

  function automatic logic [7:0] mem_byte(int idx);
    logic [31:0] w;
    w = mem_words[(idx >> 2) & 63];
    return w[8*(idx % 4) +: 8];
  endfunction

  // Textbook bit-at-a-time model driven by width/poly/reflection parameters.
  function automatic logic [31:0] model_crc(int v, int src, int len);
    int          w;
    logic [63:0] poly, crc, mask, b;
    logic [63:0] xo;
    bit          refl;
    logic [7:0]  byt, rb;
    logic [31:0] out;
    case (v)
      0:       begin w = 8;  poly = 64'h07;       crc = 64'h0;        xo = 64'h0;        refl = 0; end
      1:       begin w = 16; poly = 64'h1021;     crc = 64'hFFFF;     xo = 64'h0;        refl = 0; end
      default: begin w = 32; poly = 64'h04C11DB7; crc = 64'hFFFFFFFF; xo = 64'hFFFFFFFF; refl = 1; end
    endcase
    mask = (64'h1 << w) - 64'h1;
    for (int i = 0; i < len; i++) begin
      byt = mem_byte((src & ~3) + i);
      for (int j = 0; j < 8; j++) rb[j] = byt[7-j];
      b   = refl ? {56'h0, rb} : {56'h0, byt};
      crc = crc ^ (b << (w - 8));
      for (int j = 0; j < 8; j++) begin
        if (crc[w-1]) crc = ((crc << 1) ^ poly) & mask;
        else          crc = (crc << 1) & mask;
      end
    end
    out = crc[31:0];
    if (refl) for (int j = 0; j < 32; j++) out[j] = crc[31-j];
    return out ^ xo[31:0];
  endfunction

  task automatic wait_done(output logic [31:0] st);
    st = '0;
    for (int i = 0; i < 4000; i++) begin
      ahb_read(A_STAT, st);
      if (st[1]) break;
    end
  endtask

  task automatic run_job(int v, bit mode, bit ien, int src, int len, logic [31:0] exp_reg,
                         output logic [31:0] res, output logic [31:0] st);
    ahb_write(A_SRC, src);
    ahb_write(A_LEN, len);
    ahb_write(A_EXP, exp_reg);
    ahb_write(A_CTRL, {27'h0, ien, v[1:0], mode, 1'b1});
    wait_done(st);
    ahb_read(A_RES, res);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    ahb_read(A_STAT, d);  chk("R2 status after reset", d, 32'h0);
    ahb_read(A_RES, d);   chk("R1 result after reset", d, 32'h0);
    ahb_read(A_CTRL, d);  chk("R1 control after reset", d, 32'h0);
    chk("R8 irq after reset", {31'h0, irq}, 32'h0);
    chk("R11 hreadyout/hresp", {30'h0, hreadyout, hresp}, 32'h2);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    ahb_write(A_SRC, 32'h0000_1234);
    ahb_write(A_LEN, 32'hABCD_5678);
    ahb_write(A_EXP, 32'hDEAD_BEEF);
    ahb_write(A_CTRL, 32'h0000_001E);
    ahb_read(A_SRC, d);  chk("R1 source readback", d, 32'h0000_1234);
    ahb_read(A_LEN, d);  chk("R1 length 16-bit readback", d, 32'h0000_5678);
    ahb_read(A_EXP, d);  chk("R1 expected readback", d, 32'hDEAD_BEEF);
    ahb_read(A_CTRL, d); chk("R1 control fields", d, 32'h0000_001E);
    ahb_write(A_CTRL, 32'h0);
  endtask

  task automatic t_known();
    logic [31:0] r, s;
    mem_words[0] = 32'h3433_3231;
    mem_words[1] = 32'h3837_3635;
    mem_words[2] = 32'hA5A5_A539;   // filler in unused lanes, R5
    run_job(0, 0, 0, 0, 9, 0, r, s);
    chk("R3 R4 CRC-8 of 123456789", r, 32'h0000_00F4);
    run_job(1, 0, 0, 0, 9, 0, r, s);
    chk("R3 R5 CRC-16 of 123456789", r, 32'h0000_29B1);
    run_job(2, 0, 0, 0, 9, 0, r, s);
    chk("R3 CRC-32 of 123456789", r, 32'hCBF4_3926);
    run_job(3, 0, 0, 0, 9, 0, r, s);
    chk("R3 variant 3 as CRC-32", r, 32'hCBF4_3926);
    chk("R2 busy clear at end", {31'h0, s[0]}, 32'h0);
  endtask

  task automatic t_lengths();
    logic [31:0] r, s, lcg;
    int g0;
    lcg = 32'h1357_9BDF;
    for (int i = 16; i < 32; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      mem_words[i] = lcg;
    end
    for (int n = 1; n <= 8; n++) begin
      run_job(2, 0, 0, 32'h40, n, 0, r, s);
      chk($sformatf("R5 CRC-32 length %0d", n), r, model_crc(2, 32'h40, n));
    end
    run_job(1, 0, 0, 32'h44, 3, 0, r, s);
    chk("R5 CRC-16 length 3", r, model_crc(1, 32'h44, 3));
    run_job(0, 0, 0, 32'h48, 6, 0, r, s);
    chk("R4 CRC-8 length 6", r, model_crc(0, 32'h48, 6));
    g0 = n_grants;
    run_job(2, 0, 0, 32'h42, 7, 0, r, s);
    chk("R10 misaligned source treated aligned", r, model_crc(2, 32'h40, 7));
    chk("R10 request count for 7 bytes", n_grants - g0, 2);
    chk("R10 first address", grant_log[g0[7:0]], 32'h40);
    chk("R10 second address", grant_log[(g0 + 1) & 255], 32'h44);
  endtask

  task automatic t_zero();
    logic [31:0] r, s;
    int g0;
    g0 = n_grants;
    run_job(0, 0, 0, 0, 0, 0, r, s);  chk("R6 CRC-8 empty", r, 32'h0);
    run_job(1, 0, 0, 0, 0, 0, r, s);  chk("R6 CRC-16 empty", r, 32'h0000_FFFF);
    run_job(2, 0, 0, 0, 0, 0, r, s);  chk("R6 CRC-32 empty", r, 32'h0);
    chk("R6 no requests for empty jobs", n_grants - g0, 0);
  endtask

  task automatic t_check();
    logic [31:0] r, s;
    run_job(2, 1, 0, 0, 9, 32'hCBF4_3926, r, s);
    chk("R7 check mode match status", s, 32'h6);
    chk("R7 result in check mode", r, 32'hCBF4_3926);
    run_job(2, 1, 0, 0, 9, 32'hCBF4_3927, r, s);
    chk("R7 check mode mismatch status", s, 32'h2);
    run_job(2, 0, 0, 0, 9, 32'hCBF4_3926, r, s);
    chk("R7 operation mode has no match", s, 32'h2);
  endtask

  task automatic t_irq();
    logic [31:0] r, s;
    run_job(1, 0, 1, 0, 5, 0, r, s);
    chk("R8 irq after done with enable", {31'h0, irq}, 32'h1);
    ahb_write(A_STAT, 32'h2);
    chk("R8 irq after W1C", {31'h0, irq}, 32'h0);
    ahb_read(A_STAT, s);
    chk("R8 done cleared by W1C", s, 32'h0);
    run_job(1, 0, 0, 0, 5, 0, r, s);
    chk("R8 done without enable", s & 32'h2, 32'h2);
    chk("R8 irq gated by enable", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_busy();
    logic [31:0] r, s;
    int g0;
    gnt_lat = 20; rv_lat = 20;
    g0 = n_grants;
    ahb_write(A_SRC, 0);
    ahb_write(A_LEN, 9);
    ahb_write(A_CTRL, 32'h0000_0009);       // CRC-32, start
    ahb_read(A_STAT, s);
    chk("R2 busy while running", s & 32'h1, 32'h1);
    ahb_write(A_LEN, 3);
    ahb_write(A_SRC, 32'h40);
    ahb_write(A_CTRL, 32'h0000_0001);       // start of CRC-8, must drop
    wait_done(s);
    ahb_read(A_RES, r);
    chk("R9 result unaffected by busy writes", r, 32'hCBF4_3926);
    ahb_read(A_LEN, r);
    chk("R9 length write ignored while busy", r, 32'd9);
    ahb_read(A_SRC, r);
    chk("R9 source write ignored while busy", r, 32'h0);
    ahb_read(A_CTRL, r);
    chk("R9 control write ignored while busy", r, 32'h0000_0008);
    repeat (200) @(negedge clk);
    chk("R9 dropped start made no requests", n_grants - g0, 3);
    chk("R2 idle after job", {31'h0, s[0]}, 32'h0);
    gnt_lat = 0; rv_lat = 0;
  endtask

  initial begin : main
    for (int i = 0; i < 64; i++) mem_words[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_regs();
    t_known();
    t_lengths();
    t_zero();
    t_check();
    t_irq();
    t_busy();
    gnt_lat = 2; rv_lat = 3;
    t_known();
    chk("R10 no request while data outstanding", viol, 0);
    report_and_end();
  end

endmodule